// File: doc/BRIEF.md
# Virtualized Shared Coprocessor Request Scheduler

This block fronts a single shared coprocessor so that several partitions each appear to own a private instance of it. Every partition gets its own access window: a control register, a command register, a status register, a DMA length register and a local word memory for data and descriptors. Each window also has its own interrupt line and its own DMA request line. A hardware picker decides which partition's job runs next. It follows a 16-entry cyclic slot table, so the order does not depend on software coordination between cores.

Host accesses arrive on a valid/ready channel. A transfer happens on a rising edge where `host_valid` and `host_ready` are both high. While `host_valid` is high and `host_ready` is low, the initiator must hold the port, address, direction and data stable. Read data returns one cycle after the transfer, flagged by `host_rvalid`, and the channel has no read back-pressure. The coprocessor is modelled by three pieces: a start pulse tagged with the port ID, a completion pulse that returns that tag, and a memory master path into the running port's window. The slot table is loaded through a configuration port that accepts writes only from a trusted source and only until a sticky lock is raised.

Top module: `vcopro_sched`

## Requirements
- R1: A host write to one port's window (registers or memory) never changes any register or memory word of another port.
- R2: Port register offsets are: 0 control (bit 0 enables), 1 command (bit 0 is go), 2 status (bits [1:0]: 0 idle, 1 pending, 2 running, 3 done), 3 DMA length. Address MSB = 1 selects a memory word. A go write moves the port from idle to pending only when control bit 0 is set and the port is idle; otherwise the go write is ignored.
- R3: When the coprocessor is free and `cp_ready` is high, the picker issues the current slot's owner if that port is pending. Otherwise it issues the first pending port after the owner in cyclic port order. The slot pointer advances by one per issue and wraps after 16 slots.
- R4: Only one job occupies the coprocessor at a time. No new `cp_start` is issued until `cp_done` arrives, and ports that request in the meantime stay pending.
- R5: `cp_done` moves only the port named by `cp_done_tag` from running to done and raises only that port's `irq` bit. Writing 1 to status bit 0 of a done port returns it to idle and drops its `irq`.
- R6: A configuration write is accepted only when `cfg_trusted` is high, the block is not locked and `cfg_port` < N. `cfg_lock` sets a lock that stays set until reset. A rejected write leaves the table unchanged and raises `cfg_err` for the following cycle.
- R7: After reset every port is idle with control cleared, and `irq`, `dma_req`, `cp_start` and `cfg_err` are all low.
- R8: Writing length L to the DMA register raises that port's `dma_req` until `dma_ack` if the bytes already acknowledged in the current round plus L fit within `DMA_BUDGET`. Otherwise the request is held until the next round, which starts every `ROUND_CYCLES` cycles and clears the count. Each port has its own budget.
- R9: The coprocessor memory path reaches only the running port's memory. When both paths target the same window, the coprocessor path wins and `host_ready` is low; host accesses to other windows proceed.
- R10: Host read data appears on `host_rdata` with `host_rvalid` high in the cycle after the read transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_valid | input | 1 | Host access request |
| host_ready | output | 1 | Host access accepted this cycle |
| host_we | input | 1 | Host write (1) or read (0) |
| host_port | input | PW | Target port window |
| host_addr | input | AW | Word address within the window |
| host_wdata | input | DW | Host write data |
| host_rvalid | output | 1 | Read data valid |
| host_rdata | output | DW | Read data |
| cfg_we | input | 1 | Slot table write strobe |
| cfg_trusted | input | 1 | Write comes from a trusted source |
| cfg_lock | input | 1 | Sticky lock request |
| cfg_idx | input | SW | Slot index to write |
| cfg_port | input | PW | Owner port for that slot |
| cfg_err | output | 1 | Previous configuration write rejected |
| cp_ready | input | 1 | Coprocessor can take a job |
| cp_start | output | 1 | Job start pulse |
| cp_tag | output | PW | Port owning the running job |
| cp_done | input | 1 | Job completion pulse |
| cp_done_tag | input | PW | Port tag of the completed job |
| cp_mem_req | input | 1 | Coprocessor memory access |
| cp_mem_we | input | 1 | Coprocessor memory write |
| cp_mem_addr | input | MAW | Coprocessor memory word address |
| cp_mem_wdata | input | DW | Coprocessor write data |
| cp_mem_rdata | output | DW | Coprocessor read data (next cycle) |
| irq | output | N_PORTS | Per-port completion interrupt |
| dma_req | output | N_PORTS | Per-port DMA request |
| dma_ack | input | N_PORTS | Per-port DMA acknowledge |

## Verification
The bench builds the block with three ports, so cyclic port search has to wrap at a count that is not a power of two. That width also leaves port ID 3 encodable but out of range, which exercises the configuration rejection. `ROUND_CYCLES` is 64 and `DMA_BUDGET` is 64, so a budget overrun followed by its release at a round boundary happens within a short run. A slot table with repeated owners drives the picker through owner hits, cyclic fall-through and the post-lock frozen case. The bench's coprocessor model writes a tagged word into the running window, which makes the memory routing observable.

// File: rtl/vcopro_pkg.sv
package vcopro_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PEND = 2'd1,
    ST_RUN  = 2'd2,
    ST_DONE = 2'd3
  } job_state_e;

  localparam logic [1:0] OFS_CTRL = 2'd0;
  localparam logic [1:0] OFS_CMD  = 2'd1;
  localparam logic [1:0] OFS_STAT = 2'd2;
  localparam logic [1:0] OFS_DMA  = 2'd3;
endpackage

// File: rtl/vcopro_port.sv
module vcopro_port
  import vcopro_pkg::*;
#(
  parameter int MEM_DEPTH  = 16,
  parameter int MAW        = 4,
  parameter int DW         = 32,
  parameter int LW         = 16,
  parameter int DMA_BUDGET = 256
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           h_sel_i,
  input  logic           h_we_i,
  input  logic           h_mem_i,
  input  logic [MAW-1:0] h_addr_i,
  input  logic [DW-1:0]  h_wdata_i,
  output logic [DW-1:0]  h_rdata_o,
  input  logic           c_sel_i,
  input  logic           c_we_i,
  input  logic [MAW-1:0] c_addr_i,
  input  logic [DW-1:0]  c_wdata_i,
  output logic [DW-1:0]  c_rdata_o,
  input  logic           grant_i,
  input  logic           done_i,
  input  logic           round_start_i,
  input  logic           dma_ack_i,
  output logic           pending_o,
  output logic           running_o,
  output logic           irq_o,
  output logic           dma_req_o
);
  logic [DW-1:0] mem [MEM_DEPTH];
  logic          en_q;
  job_state_e    st_q;
  logic [LW-1:0] dma_len_q;
  logic [LW-1:0] dma_used_q;
  logic          dma_pend_q;
  logic [1:0]    ofs;
  logic          wr_reg;
  logic          dma_fits;
  logic          dma_take;
  logic [DW-1:0] reg_word;

  assign ofs      = h_addr_i[1:0];
  assign wr_reg   = h_sel_i && h_we_i && !h_mem_i;
  assign dma_fits = ({1'b0, dma_used_q} + {1'b0, dma_len_q}) <= (LW+1)'(DMA_BUDGET);
  assign dma_req_o = dma_pend_q && dma_fits;
  assign dma_take  = dma_ack_i && dma_req_o;

  assign pending_o = (st_q == ST_PEND);
  assign running_o = (st_q == ST_RUN);
  assign irq_o     = (st_q == ST_DONE);

  always_comb begin
    case (ofs)
      OFS_CTRL: reg_word = DW'(en_q);
      OFS_STAT: reg_word = DW'(st_q);
      OFS_DMA:  reg_word = DW'(dma_len_q);
      default:  reg_word = '0;
    endcase
  end

  // local memory: coprocessor path has priority inside this window
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_DEPTH; i++) mem[i] <= '0;
    end else if (c_sel_i && c_we_i) begin
      mem[c_addr_i] <= c_wdata_i;
    end else if (h_sel_i && h_we_i && h_mem_i) begin
      mem[h_addr_i] <= h_wdata_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h_rdata_o <= '0;
      c_rdata_o <= '0;
    end else begin
      if (h_sel_i && !h_we_i) h_rdata_o <= h_mem_i ? mem[h_addr_i] : reg_word;
      if (c_sel_i && !c_we_i) c_rdata_o <= mem[c_addr_i];
    end
  end

  // job state and control
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      st_q <= ST_IDLE;
    end else begin
      if (wr_reg && ofs == OFS_CTRL) en_q <= h_wdata_i[0];
      if (done_i && st_q == ST_RUN)
        st_q <= ST_DONE;
      else if (grant_i && st_q == ST_PEND)
        st_q <= ST_RUN;
      else if (wr_reg && ofs == OFS_CMD && h_wdata_i[0] && en_q && st_q == ST_IDLE)
        st_q <= ST_PEND;
      else if (wr_reg && ofs == OFS_STAT && h_wdata_i[0] && st_q == ST_DONE)
        st_q <= ST_IDLE;
    end
  end

  // DMA request with per-round byte budget
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dma_len_q  <= '0;
      dma_used_q <= '0;
      dma_pend_q <= 1'b0;
    end else begin
      if (wr_reg && ofs == OFS_DMA) begin
        dma_len_q  <= h_wdata_i[LW-1:0];
        dma_pend_q <= 1'b1;
      end else if (dma_take) begin
        dma_pend_q <= 1'b0;
      end
      if (round_start_i) dma_used_q <= dma_take ? dma_len_q : '0;
      else if (dma_take) dma_used_q <= dma_used_q + dma_len_q;
    end
  end

  AST_GO_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PEND && $past(st_q) == ST_IDLE) |-> $past(en_q)); // R2
  AST_IRQ_FROM_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(done_i)); // R5
  AST_DMA_IN_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
    dma_used_q <= LW'(DMA_BUDGET)); // R8
endmodule

// File: rtl/vcopro_slot_table.sv
module vcopro_slot_table #(
  parameter int N_PORTS = 4,
  parameter int SLOTS   = 16,
  parameter int PW      = 2,
  parameter int SW      = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we_i,
  input  logic          cfg_trusted_i,
  input  logic          cfg_lock_i,
  input  logic [SW-1:0] cfg_idx_i,
  input  logic [PW-1:0] cfg_port_i,
  input  logic [SW-1:0] rd_idx_i,
  output logic [PW-1:0] owner_o,
  output logic          cfg_err_o
);
  logic [PW-1:0]       tbl [SLOTS];
  logic [SLOTS*PW-1:0] tbl_flat;
  logic                locked_q;
  logic                accept;

  assign accept  = cfg_we_i && cfg_trusted_i && !locked_q && (int'(cfg_port_i) < N_PORTS);
  assign owner_o = tbl[rd_idx_i];

  for (genvar g = 0; g < SLOTS; g++) begin : g_flat
    assign tbl_flat[g*PW +: PW] = tbl[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked_q  <= 1'b0;
      cfg_err_o <= 1'b0;
      for (int i = 0; i < SLOTS; i++) tbl[i] <= PW'(i % N_PORTS);
    end else begin
      if (cfg_lock_i) locked_q <= 1'b1;
      cfg_err_o <= cfg_we_i && !accept;
      if (accept) tbl[cfg_idx_i] <= cfg_port_i;
    end
  end

  AST_TABLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> $stable(tbl_flat)); // R6
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> locked_q); // R6
endmodule

// File: rtl/vcopro_picker.sv
module vcopro_picker #(
  parameter int N_PORTS = 4,
  parameter int SLOTS   = 16,
  parameter int PW      = 2,
  parameter int SW      = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_PORTS-1:0] pending_i,
  input  logic [PW-1:0]      owner_i,
  input  logic               cp_ready_i,
  input  logic               cp_done_i,
  input  logic [PW-1:0]      cp_done_tag_i,
  output logic [SW-1:0]      slot_o,
  output logic [N_PORTS-1:0] grant_o,
  output logic               cp_start_o,
  output logic [PW-1:0]      run_tag_o,
  output logic               busy_o
);
  logic [PW-1:0] pick;
  logic          found;
  logic          dispatch;

  // owner first, else first pending port after the owner, cyclically
  always_comb begin
    pick  = owner_i;
    found = pending_i[owner_i];
    for (int k = 1; k < N_PORTS; k++) begin
      int idx;
      idx = int'(owner_i) + k;
      if (idx >= N_PORTS) idx = idx - N_PORTS;
      if (!found && pending_i[idx]) begin
        pick  = PW'(idx);
        found = 1'b1;
      end
    end
  end

  assign dispatch = !busy_o && cp_ready_i && found;
  assign grant_o  = dispatch ? ({{(N_PORTS-1){1'b0}}, 1'b1} << pick) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_o     <= 1'b0;
      cp_start_o <= 1'b0;
      run_tag_o  <= '0;
      slot_o     <= '0;
    end else begin
      cp_start_o <= dispatch;
      if (dispatch) begin
        busy_o    <= 1'b1;
        run_tag_o <= pick;
        slot_o    <= (slot_o == SW'(SLOTS-1)) ? '0 : slot_o + 1'b1;
      end else if (cp_done_i) begin
        busy_o <= 1'b0;
      end
    end
  end

  AST_START_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    cp_start_o |=> !cp_start_o); // R4
  AST_DONE_MATCHES_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    cp_done_i |-> (busy_o && cp_done_tag_i == run_tag_o)); // R5
endmodule

// File: rtl/vcopro_sched.sv
module vcopro_sched #(
  parameter int N_PORTS      = 4,
  parameter int SLOTS        = 16,
  parameter int MEM_DEPTH    = 16,
  parameter int DW           = 32,
  parameter int LW           = 16,
  parameter int DMA_BUDGET   = 256,
  parameter int ROUND_CYCLES = 1024,
  localparam int PW  = (N_PORTS > 1) ? $clog2(N_PORTS) : 1,
  localparam int SW  = $clog2(SLOTS),
  localparam int MAW = $clog2(MEM_DEPTH),
  localparam int AW  = MAW + 1,
  localparam int RCW = $clog2(ROUND_CYCLES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_valid,
  output logic               host_ready,
  input  logic               host_we,
  input  logic [PW-1:0]      host_port,
  input  logic [AW-1:0]      host_addr,
  input  logic [DW-1:0]      host_wdata,
  output logic               host_rvalid,
  output logic [DW-1:0]      host_rdata,
  input  logic               cfg_we,
  input  logic               cfg_trusted,
  input  logic               cfg_lock,
  input  logic [SW-1:0]      cfg_idx,
  input  logic [PW-1:0]      cfg_port,
  output logic               cfg_err,
  input  logic               cp_ready,
  output logic               cp_start,
  output logic [PW-1:0]      cp_tag,
  input  logic               cp_done,
  input  logic [PW-1:0]      cp_done_tag,
  input  logic               cp_mem_req,
  input  logic               cp_mem_we,
  input  logic [MAW-1:0]     cp_mem_addr,
  input  logic [DW-1:0]      cp_mem_wdata,
  output logic [DW-1:0]      cp_mem_rdata,
  output logic [N_PORTS-1:0] irq,
  output logic [N_PORTS-1:0] dma_req,
  input  logic [N_PORTS-1:0] dma_ack
);
  logic [N_PORTS-1:0] h_sel, c_sel, done_v, grant, pending, running;
  logic [DW-1:0]      hrd [N_PORTS];
  logic [DW-1:0]      crd [N_PORTS];
  logic               host_acc, busy, round_start;
  logic [PW-1:0]      owner, rd_port_q;
  logic               rd_ok_q;
  logic [SW-1:0]      slot;
  logic [RCW-1:0]     rcnt_q;

  // coprocessor path owns the running window; host waits only on that window
  assign host_ready = !(cp_mem_req && busy && host_port == cp_tag);
  assign host_acc   = host_valid && host_ready;

  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    assign h_sel[p]  = host_acc && (host_port == PW'(p));
    assign c_sel[p]  = cp_mem_req && busy && (cp_tag == PW'(p));
    assign done_v[p] = cp_done && (cp_done_tag == PW'(p));

    vcopro_port #(
      .MEM_DEPTH(MEM_DEPTH), .MAW(MAW), .DW(DW), .LW(LW), .DMA_BUDGET(DMA_BUDGET)
    ) u_port (
      .clk(clk), .rst_n(rst_n),
      .h_sel_i(h_sel[p]), .h_we_i(host_we), .h_mem_i(host_addr[AW-1]),
      .h_addr_i(host_addr[MAW-1:0]), .h_wdata_i(host_wdata), .h_rdata_o(hrd[p]),
      .c_sel_i(c_sel[p]), .c_we_i(cp_mem_we), .c_addr_i(cp_mem_addr),
      .c_wdata_i(cp_mem_wdata), .c_rdata_o(crd[p]),
      .grant_i(grant[p]), .done_i(done_v[p]), .round_start_i(round_start),
      .dma_ack_i(dma_ack[p]), .pending_o(pending[p]), .running_o(running[p]),
      .irq_o(irq[p]), .dma_req_o(dma_req[p])
    );
  end

  vcopro_slot_table #(.N_PORTS(N_PORTS), .SLOTS(SLOTS), .PW(PW), .SW(SW)) u_table (
    .clk(clk), .rst_n(rst_n), .cfg_we_i(cfg_we), .cfg_trusted_i(cfg_trusted),
    .cfg_lock_i(cfg_lock), .cfg_idx_i(cfg_idx), .cfg_port_i(cfg_port),
    .rd_idx_i(slot), .owner_o(owner), .cfg_err_o(cfg_err)
  );

  vcopro_picker #(.N_PORTS(N_PORTS), .SLOTS(SLOTS), .PW(PW), .SW(SW)) u_picker (
    .clk(clk), .rst_n(rst_n), .pending_i(pending), .owner_i(owner),
    .cp_ready_i(cp_ready), .cp_done_i(cp_done), .cp_done_tag_i(cp_done_tag),
    .slot_o(slot), .grant_o(grant), .cp_start_o(cp_start), .run_tag_o(cp_tag),
    .busy_o(busy)
  );

  assign round_start = (rcnt_q == RCW'(ROUND_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rcnt_q      <= '0;
      host_rvalid <= 1'b0;
      rd_port_q   <= '0;
      rd_ok_q     <= 1'b0;
    end else begin
      rcnt_q      <= round_start ? '0 : rcnt_q + 1'b1;
      host_rvalid <= host_acc && !host_we;
      if (host_acc && !host_we) begin
        rd_port_q <= host_port;
        rd_ok_q   <= int'(host_port) < N_PORTS;
      end
    end
  end

  assign host_rdata   = rd_ok_q ? hrd[rd_port_q] : '0;
  assign cp_mem_rdata = crd[cp_tag];

  AST_ONE_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(running) <= 1); // R4
  AST_START_HAS_RUNNER: assert property (@(posedge clk) disable iff (!rst_n)
    cp_start |-> running[cp_tag]); // R3
  AST_READ_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
    (host_valid && host_ready && !host_we) |=> host_rvalid); // R10
endmodule

// File: tb/vcopro_sched_test.sv
`timescale 1ns/1ps
module vcopro_sched_test;
  localparam int N = 3;
  localparam int RND = 64;
  localparam logic [4:0] A_CTRL = 5'd0, A_CMD = 5'd1, A_STAT = 5'd2, A_DMA = 5'd3;

  logic clk = 0, rst_n = 0;
  logic host_valid = 0, host_we = 0, host_ready, host_rvalid;
  logic [1:0] host_port = 0;
  logic [4:0] host_addr = 0;
  logic [31:0] host_wdata = 0, host_rdata;
  logic cfg_we = 0, cfg_trusted = 0, cfg_lock = 0, cfg_err;
  logic [3:0] cfg_idx = 0;
  logic [1:0] cfg_port = 0;
  logic cp_ready = 0, cp_start, cp_done = 0;
  logic [1:0] cp_tag, cp_done_tag = 0;
  logic cp_mem_req = 0, cp_mem_we = 0;
  logic [3:0] cp_mem_addr = 0;
  logic [31:0] cp_mem_wdata = 0, cp_mem_rdata;
  logic [N-1:0] irq, dma_req, dma_ack = 0;

  int n_chk = 0, n_bad = 0, n_start = 0, n_done = 0, cyc = 0;
  int exp_q[$];
  logic [31:0] rd;
  logic err;

  always #10 clk = ~clk;
  always @(posedge clk) if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  vcopro_sched #(.N_PORTS(N), .SLOTS(16), .MEM_DEPTH(16), .DW(32), .LW(16),
                 .DMA_BUDGET(64), .ROUND_CYCLES(RND)) uut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hwrite(int p, logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    host_valid = 1; host_we = 1; host_port = 2'(p); host_addr = a; host_wdata = d;
    #1;
    while (!host_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    host_valid = 0; host_we = 0;
  endtask

  task automatic hread(int p, logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    host_valid = 1; host_we = 0; host_port = 2'(p); host_addr = a;
    #1;
    while (!host_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    host_valid = 0;
    check("R10 rvalid", 32'(host_rvalid), 32'd1);
    d = host_rdata;
  endtask

  task automatic cfgw(logic trusted, int idx, int port, output logic e);
    @(negedge clk);
    cfg_we = 1; cfg_trusted = trusted; cfg_idx = 4'(idx); cfg_port = 2'(port);
    @(negedge clk);
    cfg_we = 0; cfg_trusted = 0;
    e = cfg_err;
  endtask

  task automatic ack(int p);
    @(negedge clk); dma_ack[p] = 1'b1;
    @(negedge clk); dma_ack = '0;
  endtask

  task automatic wait_done(int target);
    while (n_done < target) begin @(negedge clk); #1; end
  endtask

  // coprocessor model and scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && cp_start) begin
        automatic logic [1:0] t = cp_tag;
        n_start++;
        if (exp_q.size() == 0) check("R3 unexpected start", 32'(t), 32'hFFFF);
        else check("R3 dispatch order", 32'(t), 32'(exp_q.pop_front()));
        cp_mem_req = 1; cp_mem_we = 1; cp_mem_addr = 4'd4; cp_mem_wdata = 32'hC0DE0000 | 32'(t);
        @(negedge clk);
        cp_mem_req = 0; cp_mem_we = 0;
        @(negedge clk);
        @(negedge clk);
        cp_done = 1; cp_done_tag = t;
        @(negedge clk);
        cp_done = 0;
        check("R5 irq of finished port", 32'(irq[t]), 32'd1);
        n_done++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R7 reset state
    check("R7 irq", 32'(irq), 0);
    check("R7 dma_req", 32'(dma_req), 0);
    check("R7 cp_start", 32'(cp_start), 0);
    check("R7 cfg_err", 32'(cfg_err), 0);
    hread(0, A_STAT, rd); check("R7 status idle", rd, 0);
    hread(1, A_CTRL, rd); check("R7 ctrl clear", rd, 0);

    // R6 trusted configuration
    cfgw(1, 0, 2, err); check("R6 accept", 32'(err), 0);
    cfgw(1, 1, 0, err);
    cfgw(1, 2, 1, err);
    cfgw(1, 3, 0, err);
    cfgw(1, 4, 0, err);
    cfgw(1, 5, 0, err);
    cfgw(1, 6, 2, err);
    cfgw(1, 7, 0, err); check("R6 accept", 32'(err), 0);
    cfgw(0, 6, 0, err); check("R6 untrusted rejected", 32'(err), 1);
    cfgw(1, 6, 3, err); check("R6 port out of range rejected", 32'(err), 1);

    // R1 isolation and R2 go ignored when disabled
    hwrite(0, A_CTRL, 1);
    hread(1, A_CTRL, rd); check("R1 ctrl of other port", rd, 0);
    hwrite(1, A_CMD, 1);
    hread(1, A_STAT, rd); check("R2 go ignored when disabled", rd, 0);
    hwrite(1, A_CTRL, 1);
    hwrite(2, A_CTRL, 1);
    hwrite(0, 5'h18, 32'hAAAA0000);
    hwrite(1, 5'h18, 32'hBBBB1111);
    hread(0, 5'h18, rd); check("R1 mem port0", rd, 32'hAAAA0000);
    hread(1, 5'h18, rd); check("R1 mem port1", rd, 32'hBBBB1111);
    hread(2, 5'h18, rd); check("R1 mem port2 untouched", rd, 0);

    // R3 ordering under the slot table
    exp_q.push_back(2); exp_q.push_back(0); exp_q.push_back(1);
    hwrite(0, A_CMD, 1); hwrite(1, A_CMD, 1); hwrite(2, A_CMD, 1);
    hread(0, A_STAT, rd); check("R2 pending", rd, 1);
    hread(2, A_STAT, rd); check("R2 pending", rd, 1);
    @(negedge clk); cp_ready = 1;
    while (n_start < 1) begin @(negedge clk); #1; end
    hread(0, A_STAT, rd); check("R4 queued while busy", rd, 1);
    wait_done(3);
    check("R5 all done irq", 32'(irq), 32'h7);
    for (int p = 0; p < N; p++) begin
      hread(p, 5'h14, rd); check("R9 coprocessor write routed", rd, 32'hC0DE0000 | 32'(p));
    end
    hread(0, 5'h18, rd); check("R1 mem kept", rd, 32'hAAAA0000);
    hwrite(1, A_STAT, 1);
    check("R5 clear one irq", 32'(irq), 32'h5);
    hwrite(0, A_STAT, 1); hwrite(2, A_STAT, 1);
    check("R5 irq cleared", 32'(irq), 0);

    // R3 fall-through when owner idle
    exp_q.push_back(2);
    hwrite(2, A_CMD, 1);
    wait_done(4);
    hwrite(2, A_STAT, 1);
    cp_ready = 0;
    exp_q.push_back(1); exp_q.push_back(2);
    hwrite(1, A_CMD, 1); hwrite(2, A_CMD, 1);
    @(negedge clk); cp_ready = 1;
    wait_done(6);
    hwrite(1, A_STAT, 1); hwrite(2, A_STAT, 1);

    // R6 lock
    @(negedge clk); cfg_lock = 1;
    @(negedge clk); cfg_lock = 0;
    cfgw(1, 6, 0, err); check("R6 write after lock rejected", 32'(err), 1);
    cp_ready = 0;
    exp_q.push_back(2); exp_q.push_back(0);
    hwrite(0, A_CMD, 1); hwrite(2, A_CMD, 1);
    @(negedge clk); cp_ready = 1;
    wait_done(8);
    hwrite(0, A_CMD, 1);
    hread(0, A_STAT, rd); check("R2 go ignored when done", rd, 3);
    hwrite(0, A_STAT, 1); hwrite(2, A_STAT, 1);
    check("R3 scoreboard drained", 32'(exp_q.size()), 0);

    // R8 DMA budget
    while (cyc % RND != 3) @(negedge clk);
    hwrite(0, A_DMA, 40);
    check("R8 request within budget", 32'(dma_req[0]), 1);
    ack(0);
    check("R8 request dropped after ack", 32'(dma_req[0]), 0);
    hwrite(0, A_DMA, 40);
    @(negedge clk);
    check("R8 over budget held", 32'(dma_req[0]), 0);
    hwrite(1, A_DMA, 64);
    check("R8 per-port budget", 32'(dma_req[1]), 1);
    ack(1);
    while (cyc % RND != 2) @(negedge clk);
    check("R8 released in new round", 32'(dma_req[0]), 1);
    ack(0);
    check("R8 no stray request", 32'(dma_req), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule